// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits in the instruction fetch stage and holds a small cache of branches that have already executed. In every cycle the current fetch address is compared, combinationally, against the entries of one set. On a match the block reports a hit, a taken/not-taken prediction, the stored target, and the address fetch should use next. That next address is the stored target when the prediction is taken, and the sequential successor otherwise. Fetch can therefore redirect in the same cycle as the lookup.

When a branch resolves in execute, the update port presents the branch address, its real direction and its real target. If the branch is already present, its entry is refreshed. If not, an entry is allocated in its set. An invalid way is used first; otherwise the least-recently-updated way is replaced. Direction history is kept per entry as a two-bit saturating state machine.

A synchronous flush invalidates the whole table. The default organisation is 128 sets of 4 ways, 32-bit addresses and 4-byte instruction alignment. The set index is taken from the address bits just above the alignment bits, and the remaining upper bits form the tag.

Top module: `btb_core`

## Requirements
- R1: After reset, and after any cycle with `flush` high, every lookup misses until a new update allocates an entry.
- R2: A lookup hits only if a valid entry in the set selected by `fetch_pc[8:2]` holds the same upper bits `fetch_pc[31:9]`. A different tag in the same set misses, and the same tag in another set misses.
- R3: On a hit, `pred_target` equals the stored target. `next_fetch` equals `pred_target` when the hit predicts taken, and `fetch_pc + 4` in every other case.
- R4: An update that misses allocates an entry whose history starts at 2'b10 (weakly taken, predicts taken) if the branch was taken, and at 2'b01 (weakly not-taken, predicts not-taken) if it was not.
- R5: An update that hits moves the entry's 2-bit history one step toward 2'b11 when taken and one step toward 2'b00 when not taken, saturating at both ends. The prediction is history bit 1.
- R6: A lookup in the same cycle as an update to the same branch sees the contents from before that update. The update becomes visible to lookups from the next cycle on.
- R7: An allocating update uses the lowest-numbered invalid way of the set. If no way is invalid, it replaces the way updated least recently. Only updates refresh recency; lookups do not.
- R8: An update that hits overwrites the stored target with the resolved target.
- R9: When `flush` and `upd_valid` are high in the same cycle, the flush wins and the update is discarded.
- R10: At most one way of a set matches any lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry at the next edge |
| fetch_pc | input | 32 | Current fetch address to look up |
| hit | output | 1 | A valid entry matches `fetch_pc` |
| pred_taken | output | 1 | Matching entry predicts taken |
| pred_target | output | 32 | Target stored in the matching entry |
| next_fetch | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |

## Verification
The embedded assertions check, on every cycle, the properties that hold for any history:
- an update is visible at its own address on the following cycle, with the resolved target;
- a flush leaves the table empty;
- no set ever matches in two ways;
- the touched way becomes the youngest in the recency order.

The exact state-machine walk through saturation and hysteresis, the choice of victim after a specific sequence of updates, the pre-update view during a simultaneous lookup, and flush priority over a concurrent update depend on sequence and expected values, so only the bench's directed scenarios show them.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;

    // 2-bit direction state; bit 1 is the prediction
    typedef enum logic [1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_e;

    function automatic hist_e hist_init(input logic taken);
        return taken ? HIST_WT : HIST_WNT;
    endfunction

    function automatic hist_e hist_next(input hist_e h, input logic taken);
        hist_e r;
        r = h;
        if (taken && h != HIST_ST)
            r = hist_e'(h + 2'd1);
        else if (!taken && h != HIST_SNT)
            r = hist_e'(h - 2'd1);
        return r;
    endfunction

    function automatic logic hist_pred(input hist_e h);
        return h[1];
    endfunction

endpackage

// File: rtl/btb_match.sv
`timescale 1ns/1ps
module btb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/btb_lru.sv
`timescale 1ns/1ps
module btb_lru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);

    // age 0 = most recent, WAYS-1 = oldest; ages of a set are a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
    end

    AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (rst)
        touch |=> age_q[$past(touch_set)][$past(touch_way)] == '0); // R7

endmodule

// File: rtl/btb_core.sv
`timescale 1ns/1ps
module btb_core
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2,
    parameter int SETS    = 128,
    parameter int WAYS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] next_fetch,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - ALIGN_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        hist_e             hist;
    } entry_t;

    logic [WAYS-1:0] valid_q [SETS];
    entry_t          ent_q   [SETS][WAYS];

    // ---------------- lookup side ----------------
    logic [IDX_W-1:0]            f_idx;
    logic [TAG_W-1:0]            f_tag;
    logic [WAYS-1:0][TAG_W-1:0]  f_tags;
    logic [WAYS-1:0]             f_hit_vec;
    logic                        f_hit;
    logic [WAY_W-1:0]            f_way;
    entry_t                      f_ent;

    assign f_idx = fetch_pc[ALIGN_W +: IDX_W];
    assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_ftag
        assign f_tags[w] = ent_q[f_idx][w].tag;
    end

    btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fmatch (
        .way_valid (valid_q[f_idx]),
        .way_tag   (f_tags),
        .probe_tag (f_tag),
        .hit_vec   (f_hit_vec),
        .any_hit   (f_hit),
        .hit_way   (f_way)
    );

    assign f_ent       = ent_q[f_idx][f_way];
    assign hit         = f_hit;
    assign pred_taken  = f_hit && hist_pred(f_ent.hist);
    assign pred_target = f_ent.target;
    assign next_fetch  = pred_taken ? f_ent.target : fetch_pc + STEP;

    // ---------------- update side ----------------
    logic [IDX_W-1:0]            u_idx;
    logic [TAG_W-1:0]            u_tag;
    logic [WAYS-1:0][TAG_W-1:0]  u_tags;
    logic [WAYS-1:0]             u_hit_vec;
    logic                        u_hit;
    logic [WAY_W-1:0]            u_way;
    logic [WAY_W-1:0]            lru_way;
    logic [WAY_W-1:0]            free_way;
    logic                        have_free;
    logic [WAY_W-1:0]            sel_way;
    logic                        do_upd;
    entry_t                      new_ent;

    assign u_idx = upd_pc[ALIGN_W +: IDX_W];
    assign u_tag = upd_pc[ADDR_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_utag
        assign u_tags[w] = ent_q[u_idx][w].tag;
    end

    btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_umatch (
        .way_valid (valid_q[u_idx]),
        .way_tag   (u_tags),
        .probe_tag (u_tag),
        .hit_vec   (u_hit_vec),
        .any_hit   (u_hit),
        .hit_way   (u_way)
    );

    always_comb begin
        free_way  = '0;
        have_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[u_idx][w]) begin
                free_way  = WAY_W'(w);
                have_free = 1'b1;
            end
        end
    end

    assign do_upd  = upd_valid && !flush;
    assign sel_way = u_hit ? u_way : (have_free ? free_way : lru_way);

    always_comb begin
        new_ent.tag    = u_tag;
        new_ent.target = upd_target;
        new_ent.hist   = u_hit ? hist_next(ent_q[u_idx][u_way].hist, upd_taken)
                               : hist_init(upd_taken);
    end

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch      (do_upd),
        .touch_set  (u_idx),
        .touch_way  (sel_way),
        .query_set  (u_idx),
        .victim_way (lru_way)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (do_upd) begin
            valid_q[u_idx][sel_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_upd && !rst) ent_q[u_idx][sel_way] <= new_ent;
    end

    // ---------------- assertions ----------------
    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_hit_vec)); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> !hit); // R1

    AST_UPD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (fetch_pc != $past(upd_pc) || hit)); // R4

    AST_UPD_TARGET: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (fetch_pc != $past(upd_pc) || pred_target == $past(upd_target))); // R8

endmodule

// File: tb/btb_core_tb_top.sv
`timescale 1ns/1ps
module btb_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        hit, pred_taken;
    logic [31:0] pred_target, next_fetch;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    always #2.5 clk = ~clk;

    btb_core dut_i (
        .clk(clk), .rst(rst), .flush(flush), .fetch_pc(fetch_pc),
        .hit(hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .next_fetch(next_fetch), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    typedef struct {
        logic        e_hit;
        logic        e_tk;
        logic [31:0] e_tgt;
        logic [31:0] e_next;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // monitor: compares at the falling edge of the cycle the lookup was driven
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (hit !== e.e_hit || next_fetch !== e.e_next ||
                (e.e_hit && (pred_taken !== e.e_tk || pred_target !== e.e_tgt))) begin
                n_fail++;
                $display("FAIL %s: got hit=%0b tk=%0b tgt=%h next=%h exp hit=%0b tk=%0b tgt=%h next=%h",
                         e.req, hit, pred_taken, pred_target, next_fetch,
                         e.e_hit, e.e_tk, e.e_tgt, e.e_next);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        upd_valid = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input logic h, input logic tk,
                        input logic [31:0] tgt, input string req);
        exp_t e;
        fetch_pc = pc;
        e.e_hit  = h;
        e.e_tk   = tk;
        e.e_tgt  = tgt;
        e.e_next = (h && tk) ? tgt : pc + 32'd4;
        e.req    = req;
        q.push_back(e);
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
    endtask

    // update then look the next cycle
    task automatic upd_look(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                            input logic e_tk, input string req);
        upd(pc, tk, tgt); tick();
        look(pc, 1'b1, e_tk, tgt, req); tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        look(32'h1000, 0, 0, 0, "R1 empty after reset"); tick();

        // R6: same-cycle lookup sees old contents
        upd(32'h1000, 1, 32'h2000);
        look(32'h1000, 0, 0, 0, "R6 pre-update view"); tick();
        look(32'h1000, 1, 1, 32'h2000, "R4 alloc taken / R3 redirect"); tick();

        upd_look(32'h1200, 0, 32'h3000, 0, "R4 alloc not-taken / R3 sequential");
        look(32'h1004, 0, 0, 0, "R2 other set misses"); tick();
        look(32'h1E00, 0, 0, 0, "R2 other tag misses"); tick();
        look(32'h1000, 1, 1, 32'h2000, "R2 neighbour way kept"); tick();

        // R5 history walk on 0x1200 (starts 01)
        upd_look(32'h1200, 1, 32'h3000, 1, "R5 01->10");
        upd_look(32'h1200, 1, 32'h3000, 1, "R5 10->11");
        upd_look(32'h1200, 0, 32'h3000, 1, "R5 11->10 hysteresis");
        upd_look(32'h1200, 0, 32'h3000, 0, "R5 10->01");
        upd_look(32'h1200, 0, 32'h3000, 0, "R5 01->00");
        upd_look(32'h1200, 0, 32'h3000, 0, "R5 00 saturates");
        upd_look(32'h1200, 1, 32'h3000, 0, "R5 00->01");

        // R8 target refresh on hit
        upd_look(32'h1000, 1, 32'h2400, 1, "R8 target refresh");

        // R7 replacement
        upd_look(32'h1400, 1, 32'h4400, 1, "R7 third way");
        upd_look(32'h1600, 1, 32'h4600, 1, "R7 fourth way");
        for (int i = 0; i < 3; i++) begin
            look(32'h1200, 1, 0, 32'h3000, "R7 lookups do not refresh"); tick();
        end
        upd(32'h1800, 1, 32'h4800); tick();
        look(32'h1200, 0, 0, 0, "R7 oldest evicted"); tick();
        look(32'h1000, 1, 1, 32'h2400, "R7 survivor"); tick();
        look(32'h1400, 1, 1, 32'h4400, "R7 survivor"); tick();
        look(32'h1600, 1, 1, 32'h4600, "R7 survivor"); tick();
        look(32'h1800, 1, 1, 32'h4800, "R7 new entry"); tick();
        upd(32'h1000, 1, 32'h2400); tick();
        upd(32'h1A00, 0, 32'h5A00); tick();
        look(32'h1400, 0, 0, 0, "R7 second victim"); tick();
        look(32'h1A00, 1, 0, 32'h5A00, "R7 replacement entry"); tick();
        look(32'h1000, 1, 1, 32'h2400, "R7 refreshed way kept"); tick();

        // R9 flush beats concurrent update
        flush = 1'b1;
        upd(32'h3000, 1, 32'h6000);
        look(32'h1000, 1, 1, 32'h2400, "R9 lookup during flush"); tick();
        look(32'h3000, 0, 0, 0, "R9 update dropped"); tick();
        look(32'h1000, 0, 0, 0, "R1 flushed"); tick();
        look(32'h1800, 0, 0, 0, "R1 flushed"); tick();
        upd_look(32'h1000, 0, 32'h2000, 0, "R1 usable after flush");

        tick();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule